// File: doc/BRIEF.md
# Segmented Operand Offset Generator

This block forms the 16-bit offset of a memory operand from a small mode code, two base register values, two index register values and a displacement. The displacement may be 8 bits wide or 16 bits wide. It also reports which segment the access uses by default. A request is one cycle with `req_i` high. The offset and the segment flag come out registered on the next cycle, together with a one-cycle `valid_o` strobe.

The base register chosen decides the segment. The first base register (`base_d_i`) points into the data segment. The second base register (`base_s_i`) points into the stack segment. Every mode that uses no base register falls back to the data segment. Instruction decoding, segment register storage and physical address formation are handled elsewhere.

Mode codes on `mode_i`:

| Code | Offset |
|------|--------|
| 0 | displacement |
| 1 | one register |
| 2 | base + displacement |
| 3 | index + displacement |
| 4 | base + index |
| 5 | base + index + displacement |
| 6, 7 | reserved |

Top module: `ea_offset_gen`

## Requirements
- R1: With mode 0, the registered offset equals the displacement, and the segment flag is 0 (data).
- R2: With mode 1, the offset is a single register. When `ind_use_idx_i`=1, the register is the index selected by `idx_sel_i` (0=`idx_a_i`, 1=`idx_b_i`). Otherwise it is the base selected by `base_sel_i` (0=`base_d_i`, 1=`base_s_i`).
- R3: With mode 2, the offset is the selected base plus the displacement. For example, 0x0301 plus 0x05 gives 0x0306.
- R4: With mode 3, the offset is the selected index plus the displacement.
- R5: With mode 4, the offset is the selected base plus the selected index. The displacement has no effect.
- R6: With mode 5, the offset is the selected base plus the selected index plus the displacement.
- R7: When `disp_wide_i`=0, only `disp_i[7:0]` is used, sign-extended from bit 7. `disp_i[15:8]` has no effect.
- R8: All sums wrap modulo 2^16, and no carry is reported.
- R9: `seg_o` is 1 (stack) only when the mode uses a base register and `base_sel_i`=1. This covers modes 2, 4 and 5, and mode 1 when `ind_use_idx_i`=0. In every other case `seg_o` is 0 (data).
- R10: `valid_o` is high in exactly the cycle after each cycle in which `req_i` is high. Without a request, `offset_o` and `seg_o` hold their values. Reserved codes 6 and 7 behave as mode 0.
- R11: During and after synchronous reset, `valid_o`, `offset_o` and `seg_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code |
| base_sel_i | input | 1 | Base choice: 0 data base, 1 stack base |
| idx_sel_i | input | 1 | Index choice: 0 first index, 1 second index |
| ind_use_idx_i | input | 1 | Register mode uses an index (1) instead of a base (0) |
| disp_wide_i | input | 1 | 1: 16-bit displacement, 0: 8-bit displacement |
| disp_i | input | 16 | Displacement field |
| base_d_i | input | 16 | Data-segment base register value |
| base_s_i | input | 16 | Stack-segment base register value |
| idx_a_i | input | 16 | First index register value |
| idx_b_i | input | 16 | Second index register value |
| offset_o | output | 16 | Registered operand offset |
| seg_o | output | 1 | Registered segment: 0 data, 1 stack |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is a three-operand sum with a negative short displacement that also crosses the 16-bit boundary. A wrong sign extension, a carry leaking into the result and a wrong segment must all show at once in that case.

The stimulus builds it on purpose. It drives a narrow displacement with bit 7 set and junk in the upper byte. It pairs this with register values close to 0xFFFF and the stack base selected.

Requests are also issued back-to-back and between idle gaps, so the holding of outputs between requests is observed at the ports.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned AW = 16;

  typedef enum logic [2:0] {
    M_DIRECT   = 3'd0,
    M_REG      = 3'd1,
    M_BASE_D   = 3'd2,
    M_INDEX_D  = 3'd3,
    M_BASE_IDX = 3'd4,
    M_FULL     = 3'd5
  } ea_mode_e;

  typedef enum logic {
    SEG_DATA  = 1'b0,
    SEG_STACK = 1'b1
  } ea_seg_e;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext #(
  parameter int W = 16,
  parameter int NW = 8
) (
  input  logic [W-1:0] disp_i,
  input  logic         wide_i,
  output logic [W-1:0] disp_o
);
  localparam int PAD = W - NW;
  logic [W-1:0] narrow_ext;

  generate
    if (PAD > 0) begin : g_ext
      assign narrow_ext = {{PAD{disp_i[NW-1]}}, disp_i[NW-1:0]};
    end else begin : g_noext
      assign narrow_ext = disp_i;
    end
  endgenerate

  assign disp_o = wide_i ? disp_i : narrow_ext;
endmodule

// File: rtl/ea_operand_sel.sv
module ea_operand_sel
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   mode_i,
  input  logic         base_sel_i,
  input  logic         idx_sel_i,
  input  logic         ind_use_idx_i,
  input  logic [W-1:0] base_d_i,
  input  logic [W-1:0] base_s_i,
  input  logic [W-1:0] idx_a_i,
  input  logic [W-1:0] idx_b_i,
  output logic [W-1:0] term_a_o,
  output logic [W-1:0] term_b_o,
  output logic         use_disp_o,
  output logic         stack_o
);
  logic [W-1:0] base_v, idx_v;

  assign base_v = base_sel_i ? base_s_i : base_d_i;
  assign idx_v  = idx_sel_i  ? idx_b_i  : idx_a_i;

  always_comb begin
    term_a_o   = '0;
    term_b_o   = '0;
    use_disp_o = 1'b0;
    stack_o    = SEG_DATA;
    case (ea_mode_e'(mode_i))
      M_REG: begin
        term_a_o = ind_use_idx_i ? idx_v : base_v;
        stack_o  = !ind_use_idx_i && base_sel_i;
      end
      M_BASE_D: begin
        term_a_o   = base_v;
        use_disp_o = 1'b1;
        stack_o    = base_sel_i;
      end
      M_INDEX_D: begin
        term_a_o   = idx_v;
        use_disp_o = 1'b1;
      end
      M_BASE_IDX: begin
        term_a_o = base_v;
        term_b_o = idx_v;
        stack_o  = base_sel_i;
      end
      M_FULL: begin
        term_a_o   = base_v;
        term_b_o   = idx_v;
        use_disp_o = 1'b1;
        stack_o    = base_sel_i;
      end
      default: use_disp_o = 1'b1;
    endcase
  end

  // R5: combining two registers never folds in the displacement.
  always_comb begin
    if (mode_i == M_BASE_IDX) assert (!use_disp_o);
  end

  // R9: index-only and direct forms never report the stack segment.
  always_comb begin
    if (mode_i == M_INDEX_D || mode_i == M_DIRECT) assert (!stack_o);
  end
endmodule

// File: rtl/ea_adder3.sv
module ea_adder3 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] d_i,
  input  logic         use_d_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] d_g;

  assign d_g   = use_d_i ? d_i : '0;
  assign sum_o = a_i + b_i + d_g;
endmodule

// File: rtl/ea_offset_gen.sv
module ea_offset_gen
  import ea_pkg::*;
#(
  parameter int W = AW,
  parameter int NW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_i,
  input  logic [2:0]   mode_i,
  input  logic         base_sel_i,
  input  logic         idx_sel_i,
  input  logic         ind_use_idx_i,
  input  logic         disp_wide_i,
  input  logic [W-1:0] disp_i,
  input  logic [W-1:0] base_d_i,
  input  logic [W-1:0] base_s_i,
  input  logic [W-1:0] idx_a_i,
  input  logic [W-1:0] idx_b_i,
  output logic [W-1:0] offset_o,
  output logic         seg_o,
  output logic         valid_o
);
  logic [W-1:0] disp_x, term_a, term_b, sum;
  logic         use_disp, stack;

  ea_disp_ext #(.W(W), .NW(NW)) u_ext (
    .disp_i (disp_i),
    .wide_i (disp_wide_i),
    .disp_o (disp_x)
  );

  ea_operand_sel #(.W(W)) u_sel (
    .mode_i        (mode_i),
    .base_sel_i    (base_sel_i),
    .idx_sel_i     (idx_sel_i),
    .ind_use_idx_i (ind_use_idx_i),
    .base_d_i      (base_d_i),
    .base_s_i      (base_s_i),
    .idx_a_i       (idx_a_i),
    .idx_b_i       (idx_b_i),
    .term_a_o      (term_a),
    .term_b_o      (term_b),
    .use_disp_o    (use_disp),
    .stack_o       (stack)
  );

  ea_adder3 #(.W(W)) u_add (
    .a_i     (term_a),
    .b_i     (term_b),
    .d_i     (disp_x),
    .use_d_i (use_disp),
    .sum_o   (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_o <= '0;
      seg_o    <= SEG_DATA;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        offset_o <= sum;
        seg_o    <= stack;
      end
    end
  end

  p_valid_follows_req_r10: assert property (@(posedge clk) disable iff (rst)
    req_i |=> valid_o);
  p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !valid_o);
  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> ($stable(offset_o) && $stable(seg_o)));
  p_direct_wide_r1: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == M_DIRECT && disp_wide_i) |=>
      (offset_o == $past(disp_i) && seg_o == SEG_DATA));
  p_stack_pair_r9: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == M_BASE_IDX && base_sel_i) |=> seg_o == SEG_STACK);
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!valid_o && offset_o == '0 && !seg_o));
endmodule

// File: tb/tb_ea_offset_gen.sv
module tb_ea_offset_gen;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst;
  logic req_i, base_sel_i, idx_sel_i, ind_use_idx_i, disp_wide_i;
  logic [2:0] mode_i;
  logic [W-1:0] disp_i, base_d_i, base_s_i, idx_a_i, idx_b_i;
  logic [W-1:0] offset_o;
  logic seg_o, valid_o;

  typedef struct {
    logic [W-1:0] off;
    logic         seg;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ea_offset_gen dut (.*);

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic exp_t model(input logic [2:0] m, input logic bs, input logic is,
      input logic iu, input logic wd, input logic [W-1:0] d, input string tag);
    exp_t e;
    logic [W-1:0] dx, b, x;
    dx = wd ? d : {{8{d[7]}}, d[7:0]};            // R7
    b  = bs ? base_s_i : base_d_i;
    x  = is ? idx_b_i : idx_a_i;
    e.seg = 1'b0;
    case (m)
      3'd1: begin e.off = iu ? x : b; e.seg = !iu && bs; end   // R2
      3'd2: begin e.off = b + dx; e.seg = bs; end               // R3
      3'd3: e.off = x + dx;                                     // R4
      3'd4: begin e.off = b + x; e.seg = bs; end                // R5
      3'd5: begin e.off = b + x + dx; e.seg = bs; end           // R6
      default: e.off = dx;                                      // R1, R10
    endcase
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [2:0] m, input logic bs, input logic is, input logic iu,
      input logic wd, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    req_i = 1'b1; mode_i = m; base_sel_i = bs; idx_sel_i = is;
    ind_use_idx_i = iu; disp_wide_i = wd; disp_i = d;
    q.push_back(model(m, bs, is, iu, wd, d, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_i = 1'b0;
      disp_i = 16'hDEAD;
      mode_i = 3'd5;
    end
  endtask

  task automatic regs(input logic [W-1:0] bd, input logic [W-1:0] bsv,
      input logic [W-1:0] ia, input logic [W-1:0] ib);
    @(negedge clk);
    req_i = 1'b0;
    base_d_i = bd; base_s_i = bsv; idx_a_i = ia; idx_b_i = ib;
  endtask

  // Monitor: the scoreboard compares registered results a quarter period after each edge.
  logic [W-1:0] last_off = '0;
  logic last_seg = 1'b0;
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst && !done) begin
        if (valid_o) begin
          if (q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R10 actual=valid expected=idle");
          end else begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " offset"}, offset_o, e.off);
            chk({e.tag, " seg R9"}, {15'd0, seg_o}, {15'd0, e.seg});
            last_off = e.off;
            last_seg = e.seg;
          end
        end else begin
          chk("R10 hold offset", offset_o, last_off);
          chk("R10 hold seg", {15'd0, seg_o}, {15'd0, last_seg});
        end
      end
    end
  end

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_i = 1'b0; mode_i = '0; base_sel_i = 0; idx_sel_i = 0;
    ind_use_idx_i = 0; disp_wide_i = 0; disp_i = '0;
    base_d_i = '0; base_s_i = '0; idx_a_i = '0; idx_b_i = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R11 valid", {15'd0, valid_o}, 16'd0);
    chk("R11 offset", offset_o, 16'd0);
    chk("R11 seg", {15'd0, seg_o}, 16'd0);
    @(negedge clk);
    rst = 1'b0;

    regs(16'h0301, 16'h1000, 16'h0020, 16'h0400);
    drive(3'd2, 0, 0, 0, 0, 16'h0005, "R3 example");
    drive(3'd0, 0, 0, 0, 1, 16'h1234, "R1 direct wide");
    drive(3'd0, 1, 0, 0, 0, 16'h7F85, "R1 R7 direct narrow");
    drive(3'd1, 0, 0, 0, 0, 16'h0000, "R2 data base");
    drive(3'd1, 1, 0, 0, 0, 16'h0000, "R2 stack base");
    drive(3'd1, 1, 0, 1, 0, 16'h0000, "R2 first index");
    drive(3'd1, 0, 1, 1, 0, 16'h0000, "R2 second index");
    idle(2);
    drive(3'd3, 1, 1, 0, 1, 16'h0100, "R4 index wide");
    drive(3'd3, 0, 0, 0, 0, 16'hAAF0, "R4 R7 index negative");
    drive(3'd4, 1, 0, 0, 1, 16'h5555, "R5 pair ignores disp");
    drive(3'd4, 0, 1, 0, 0, 16'h00FF, "R5 pair data");
    drive(3'd5, 0, 1, 0, 0, 16'h0005, "R6 full");
    drive(3'd6, 1, 1, 1, 1, 16'h4321, "R10 reserved six");
    drive(3'd7, 1, 0, 0, 0, 16'h0080, "R10 reserved seven");
    idle(3);

    regs(16'hFFF0, 16'hFFFF, 16'h8001, 16'hFFFE);
    drive(3'd2, 0, 0, 0, 1, 16'h0020, "R8 base wrap");
    drive(3'd5, 1, 1, 0, 0, 16'hC380, "R8 R7 R9 full wrap negative");
    drive(3'd4, 1, 0, 0, 0, 16'h0000, "R8 R9 pair wrap stack");
    idle(1);

    for (int i = 0; i < 60; i++) begin
      regs(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      drive(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            16'($urandom), "R6 R9 random");
      if (i % 3 == 0) idle(1);
    end
    idle(3);
    done = 1;
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R10 actual=%0d pending expected=0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule